// File: doc/BRIEF.md
# Configurable SPI Master Serial Engine

This block is the serial shift engine of a single-chip-select SPI master. A producer hands it parallel words through a valid/ready transmit port; the engine asserts the frame select, shifts each word out on MOSI, samples MISO into a receive word, and reports each completed receive word with a one-cycle strobe. Words of 1 to 32 bits are supported. They can be sent most-significant bit first or least-significant bit first.

Five separate controls set the serial timing, in place of a combined clock-mode number: the edge that captures data, the idle level of SCK, a lead-in delay before the first SCK edge, the frame-start edge that picks the length of that delay, and the active level of the frame select. SCK is derived from the system clock by an even divide ratio. When the producer offers a new word at the end of a word, the engine continues with no gap and keeps the frame asserted. When it does not, the engine lets SCK rest at its idle level and releases the frame half an SCK period after the final edge.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset the frame select is at its inactive level, SCK rests at the idle level, `rxStrobe` is low, `rxData` is zero and `txReady` is high.
- R2: The frame select is driven to `cfgSelHigh` while a frame is active and to its inverse otherwise.
- R3: Word length comes from the 6-bit `cfgWordLen` field, with legal values 1 to 32. A word of N bits takes exactly 2·N SCK edges, and so ends with SCK back at its idle level.
- R4: MISO is sampled on SCK rising edges when `cfgCapFall`=0 and on falling edges when `cfgCapFall`=1. MOSI changes only at frame start, on the other SCK edge, or at a word boundary.
- R5: `cfgIdleHigh`=0 makes SCK idle low and `cfgIdleHigh`=1 makes it idle high. SCK does not toggle while the frame is inactive.
- R6: The first SCK edge follows frame assertion by one full SCK period when `cfgDelay`=1 and `cfgStartFall`=0. It follows by half a period when `cfgDelay`=1 and `cfgStartFall`=1, and also when `cfgDelay`=0.
- R7: One SCK period is `cfgDivide` system clock cycles, so consecutive SCK edges are `cfgDivide`/2 cycles apart. Only even ratios from 4 to 254 are legal.
- R8: `cfgLsbFirst`=1 shifts bit 0 first. `cfgLsbFirst`=0 shifts bit N-1 first. The same order applies to transmit and receive.
- R9: Each received word appears right-aligned on `rxData`, with every bit at or above N equal to zero.
- R10: `rxStrobe` is high for exactly one cycle per word. That cycle is the one in which SCK first shows the word's final edge, and `rxData` is valid in it.
- R11: If a new word is accepted at the final edge of the previous one, SCK continues at an unchanged edge spacing and the frame stays asserted. Otherwise the frame is released half an SCK period after the final edge.
- R12: `txReady` is high while idle and in the cycle of a word's final edge. An accepted word while idle asserts the frame in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCapFall | input | 1 | Capture edge: 0 rising, 1 falling |
| cfgIdleHigh | input | 1 | SCK idle level |
| cfgDelay | input | 1 | Enables the long lead-in before the first edge |
| cfgStartFall | input | 1 | Frame-start edge; with cfgDelay picks a half or full period |
| cfgSelHigh | input | 1 | Active level of the frame select |
| cfgLsbFirst | input | 1 | Bit order: 1 LSB first |
| cfgWordLen | input | 6 | Bits per word, 1..32 |
| cfgDivide | input | 8 | SCK divide ratio, even 4..254 |
| txValid | input | 1 | Transmit word offered |
| txData | input | 32 | Transmit word, right-aligned |
| txReady | output | 1 | Engine takes the word at this edge |
| rxData | output | 32 | Last received word, right-aligned |
| rxStrobe | output | 1 | One-cycle pulse per received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| frameSel | output | 1 | Frame / chip select |

## Verification
The main sweep covers all sixteen combinations of capture edge, idle level, delay and frame-start edge, in both bit orders and at word lengths of 1, 3, 8 and 32. A modelled slave samples MOSI and drives MISO purely from the observed SCK edges. If the capture edge or the bit order is wrong, the slave's word does not match the sent word and the received word does not match the slave's word. The single-bit length tests the edge-index limit, and 32 bits tests the full-width alignment. Multi-word bursts at ratios 6 and 10 separate continuous framing from a frame that drops between words, and the ratio-254 case tests the widest counter values for lead, edge spacing and trail.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_TRAIL = 2'd2
  } eng_state_t;

  // per-cycle commands from control to datapath
  typedef struct packed {
    logic load;     // take a new transmit word
    logic capture;  // sample miso this edge
    logic launch;   // advance mosi to the next bit
    logic done;     // final edge of the current word
  } eng_strobe_t;

endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  localparam int LEN_W  = $clog2(WORD_W) + 1,
  localparam int HALF_W = DIV_W - 1,
  localparam int IDX_W  = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCapFall,
  input  logic             cfgIdleHigh,
  input  logic             cfgDelay,
  input  logic             cfgStartFall,
  input  logic             cfgLsbFirst,
  input  logic [LEN_W-1:0] cfgWordLen,
  input  logic [DIV_W-1:0] cfgDivide,
  input  logic             txValid,
  output logic             txReady,
  output eng_strobe_t      strb,
  output logic             lsbLat,
  output logic [LEN_W-1:0] lenLat,
  output logic             sckOut,
  output logic             frameOn
);

  eng_state_t        state;
  logic [DIV_W-1:0]  halfCnt;
  logic [IDX_W-1:0]  edgeIdx;
  logic [HALF_W-1:0] halfR;
  logic              capFallR;
  logic              sckR;

  logic [HALF_W-1:0] halfLive;
  logic [DIV_W-1:0]  leadLen;
  logic [LEN_W-1:0]  lenEff;
  logic [IDX_W-1:0]  lastIdx;
  logic              expire, edgeNow, lastEdge, capNow, accept;

  always_comb begin
    halfLive = cfgDivide[DIV_W-1:1];
    if (halfLive < HALF_W'(2)) halfLive = HALF_W'(2);
    leadLen = (cfgDelay && !cfgStartFall) ? {halfLive, 1'b0} : {1'b0, halfLive};
    lenEff  = ((cfgWordLen == '0) || (cfgWordLen > LEN_W'(WORD_W)))
              ? LEN_W'(WORD_W) : cfgWordLen;
    lastIdx  = {lenLat, 1'b0} - IDX_W'(1);
    expire   = (halfCnt == '0);
    edgeNow  = (state == ST_RUN) && expire;
    lastEdge = edgeNow && (edgeIdx == lastIdx);
    capNow   = edgeNow && ((~sckR) ^ capFallR);
    txReady  = (state == ST_IDLE) || lastEdge;
    accept   = txValid && txReady;
    strb.load    = accept;
    strb.capture = capNow;
    strb.launch  = edgeNow && !capNow && (edgeIdx != '0);
    strb.done    = lastEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      edgeIdx  <= '0;
      halfR    <= HALF_W'(2);
      capFallR <= 1'b0;
      lsbLat   <= 1'b0;
      lenLat   <= LEN_W'(1);
      sckR     <= 1'b0;
      frameOn  <= 1'b0;
    end else begin
      if (accept) begin
        capFallR <= cfgCapFall;
        lsbLat   <= cfgLsbFirst;
        lenLat   <= lenEff;
        halfR    <= halfLive;
      end
      unique case (state)
        ST_IDLE: begin
          sckR <= cfgIdleHigh;
          if (accept) begin
            frameOn <= 1'b1;
            halfCnt <= leadLen - DIV_W'(1);
            edgeIdx <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (expire) begin
            sckR    <= ~sckR;
            halfCnt <= {1'b0, halfR} - DIV_W'(1);
            if (lastEdge) begin
              edgeIdx <= '0;
              if (!accept) state <= ST_TRAIL;
            end else begin
              edgeIdx <= edgeIdx + IDX_W'(1);
            end
          end else begin
            halfCnt <= halfCnt - DIV_W'(1);
          end
        end
        ST_TRAIL: begin
          if (expire) begin
            frameOn <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            halfCnt <= halfCnt - DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sckOut = sckR;

endmodule

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int LEN_W = $clog2(WORD_W) + 1,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  eng_strobe_t       strb,
  input  logic              lsbLat,
  input  logic [LEN_W-1:0]  lenLat,
  input  logic [WORD_W-1:0] txData,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxData,
  output logic              rxStrobe
);

  logic [WORD_W-1:0] txShift, rxShift, rxIns, rxNext;
  logic [LEN_W-1:0]  lenM1;
  logic [POS_W-1:0]  topPos;

  always_comb begin
    lenM1  = lenLat - LEN_W'(1);
    topPos = lenM1[POS_W-1:0];
    mosi   = lsbLat ? txShift[0] : txShift[topPos];
    if (lsbLat) rxIns = (rxShift >> 1) | (WORD_W'(miso) << topPos);
    else        rxIns = {rxShift[WORD_W-2:0], miso};
    rxNext = strb.capture ? rxIns : rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      rxData   <= '0;
      rxStrobe <= 1'b0;
    end else begin
      if (strb.load)        txShift <= txData;
      else if (strb.launch) txShift <= lsbLat ? (txShift >> 1) : (txShift << 1);
      if (strb.load)        rxShift <= '0;
      else                  rxShift <= rxNext;
      if (strb.done)        rxData  <= rxNext;
      rxStrobe <= strb.done;
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCapFall,
  input  logic              cfgIdleHigh,
  input  logic              cfgDelay,
  input  logic              cfgStartFall,
  input  logic              cfgSelHigh,
  input  logic              cfgLsbFirst,
  input  logic [LEN_W-1:0]  cfgWordLen,
  input  logic [DIV_W-1:0]  cfgDivide,
  input  logic              txValid,
  input  logic [WORD_W-1:0] txData,
  output logic              txReady,
  output logic [WORD_W-1:0] rxData,
  output logic              rxStrobe,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              frameSel
);

  eng_strobe_t      strb;
  logic             lsbLat;
  logic [LEN_W-1:0] lenLat;
  logic             frameOn;

  spi_eng_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgCapFall(cfgCapFall), .cfgIdleHigh(cfgIdleHigh), .cfgDelay(cfgDelay),
    .cfgStartFall(cfgStartFall), .cfgLsbFirst(cfgLsbFirst),
    .cfgWordLen(cfgWordLen), .cfgDivide(cfgDivide),
    .txValid(txValid), .txReady(txReady), .strb(strb),
    .lsbLat(lsbLat), .lenLat(lenLat), .sckOut(sck), .frameOn(frameOn)
  );

  spi_eng_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lsbLat(lsbLat), .lenLat(lenLat),
    .txData(txData), .miso(miso), .mosi(mosi),
    .rxData(rxData), .rxStrobe(rxStrobe)
  );

  assign frameSel = frameOn ? cfgSelHigh : ~cfgSelHigh;

endmodule

// File: rtl/spi_engine_chk.sv
module spi_engine_chk #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(WORD_W) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgIdleHigh,
  input logic              cfgSelHigh,
  input logic [LEN_W-1:0]  cfgWordLen,
  input logic              txValid,
  input logic              txReady,
  input logic [WORD_W-1:0] rxData,
  input logic              rxStrobe,
  input logic              sck,
  input logic              frameSel
);

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> !rxStrobe);

  // R5
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSel != cfgSelHigh) ##1 ((frameSel != cfgSelHigh) && $stable(cfgIdleHigh))
    |-> (sck == cfgIdleHigh));

  // R12
  frame_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && (frameSel != cfgSelHigh)) |=> (frameSel == cfgSelHigh));

  // R9
  rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && (cfgWordLen != '0) && (cfgWordLen < LEN_W'(WORD_W)))
    |-> ((rxData >> cfgWordLen) == '0));

endmodule

bind spi_shift_engine spi_engine_chk #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgIdleHigh(cfgIdleHigh), .cfgSelHigh(cfgSelHigh),
  .cfgWordLen(cfgWordLen), .txValid(txValid), .txReady(txReady),
  .rxData(rxData), .rxStrobe(rxStrobe), .sck(sck), .frameSel(frameSel)
);

// File: tb/sim_spi_shift_engine.sv
`timescale 1ns/1ps
module sim_spi_shift_engine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCapFall = 0, cfgIdleHigh = 0, cfgDelay = 0, cfgStartFall = 0;
  logic cfgSelHigh = 0, cfgLsbFirst = 0;
  logic [5:0] cfgWordLen = 6'd8;
  logic [7:0] cfgDivide = 8'd4;
  logic txValid = 0;
  logic [31:0] txData = '0;
  logic txReady, rxStrobe, sck, mosi, frameSel;
  logic miso = 0;
  logic [31:0] rxData;

  always #10 clk = ~clk;

  spi_shift_engine u0 (
    .clk(clk), .rstN(rstN), .cfgCapFall(cfgCapFall), .cfgIdleHigh(cfgIdleHigh),
    .cfgDelay(cfgDelay), .cfgStartFall(cfgStartFall), .cfgSelHigh(cfgSelHigh),
    .cfgLsbFirst(cfgLsbFirst), .cfgWordLen(cfgWordLen), .cfgDivide(cfgDivide),
    .txValid(txValid), .txData(txData), .txReady(txReady), .rxData(rxData),
    .rxStrobe(rxStrobe), .sck(sck), .mosi(mosi), .miso(miso), .frameSel(frameSel)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  int unsigned seed = 32'h1234_5678;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  logic mCapFall = 0, mLsb = 0, mSelHigh = 0;
  int   mLen = 8, mHalf = 2;
  logic [31:0] slaveW [4];
  logic [31:0] gotW [4];
  logic [31:0] rxW [4];
  logic prevSck = 0, prevMosi = 0, prevAct = 0, firstEdge = 0;
  int capCnt = 0, wIdx = 0, edgeCnt = 0, edgeOutside = 0;
  int lastEdgeCyc = 0, frameStartCyc = 0, leadCyc = -1, trailCyc = -1;
  int spacingBad = 0, strobeCnt = 0, strobeBad = 0, assertCnt = 0, deassertCnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic act;
    int pos;
    act = (frameSel === mSelHigh);
    if (act && !prevAct) begin assertCnt++; frameStartCyc = cyc; end
    if (!act && prevAct) begin deassertCnt++; trailCyc = cyc - lastEdgeCyc; end
    if (sck !== prevSck) begin
      if (!act) edgeOutside++;
      if (!firstEdge) begin leadCyc = cyc - frameStartCyc; firstEdge = 1; end
      else if (cyc - lastEdgeCyc != mHalf) spacingBad++;
      lastEdgeCyc = cyc;
      edgeCnt++;
      if (sck ^ mCapFall) begin
        pos = mLsb ? capCnt : mLen - 1 - capCnt;
        if (wIdx < 4) gotW[wIdx][pos] = prevMosi;
        capCnt++;
        if (capCnt == mLen) begin capCnt = 0; wIdx++; end
      end
    end
    if (rxStrobe) begin
      if (strobeCnt < 4) rxW[strobeCnt] = rxData;
      strobeCnt++;
      if (sck === prevSck) strobeBad++;
    end
    pos = mLsb ? capCnt : mLen - 1 - capCnt;
    miso = (wIdx < 4) ? slaveW[wIdx][pos] : 1'b0;
    prevSck = sck; prevMosi = mosi; prevAct = act;
  end

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 13);
  endfunction

  task automatic xfer(input bit capF, input bit idleH, input bit dly, input bit stF,
                      input bit selH, input bit lsb, input int len, input int dv, input int n);
    logic [31:0] tx [4];
    logic [31:0] mask;
    int expLead;
    @(negedge clk);
    cfgCapFall = capF; cfgIdleHigh = idleH; cfgDelay = dly; cfgStartFall = stF;
    cfgSelHigh = selH; cfgLsbFirst = lsb; cfgWordLen = 6'(len); cfgDivide = 8'(dv);
    txValid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(frameSel == !selH, "R2 inactive frame level", 32'(frameSel), 32'(!selH));
    chk(sck == idleH, "R5 idle sck level", 32'(sck), 32'(idleH));
    chk(txReady == 1'b1, "R12 ready while idle", 32'(txReady), 32'd1);
    mask = (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
    for (int i = 0; i < 4; i++) begin
      tx[i] = nextRand();
      slaveW[i] = nextRand();
      gotW[i] = '0;
      rxW[i] = '0;
    end
    mCapFall = capF; mLsb = lsb; mSelHigh = selH; mLen = len; mHalf = dv / 2;
    capCnt = 0; wIdx = 0; edgeCnt = 0; edgeOutside = 0; firstEdge = 0;
    leadCyc = -1; trailCyc = -1; spacingBad = 0; strobeCnt = 0; strobeBad = 0;
    assertCnt = 0; deassertCnt = 0;
    prevSck = sck; prevMosi = mosi; prevAct = 0;
    for (int i = 0; i < n; i++) begin
      txData = tx[i]; txValid = 1;
      while (!txReady) begin @(negedge clk); #1; end
      @(negedge clk); #1;
    end
    txValid = 0;
    while (!(strobeCnt == n && frameSel == !selH)) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    expLead = (dly && !stF) ? dv : dv / 2;
    for (int i = 0; i < n; i++) begin
      chk(gotW[i] == (tx[i] & mask), "R4 R8 slave saw tx word", gotW[i], tx[i] & mask);
      chk(rxW[i] == (slaveW[i] & mask), "R8 R9 received word", rxW[i], slaveW[i] & mask);
    end
    chk(edgeCnt == 2 * len * n, "R3 edge count", 32'(edgeCnt), 32'(2 * len * n));
    chk(edgeOutside == 0, "R5 no edge outside frame", 32'(edgeOutside), 32'd0);
    chk(sck == idleH, "R3 R5 sck back at idle", 32'(sck), 32'(idleH));
    chk(leadCyc == expLead, "R6 lead-in", 32'(leadCyc), 32'(expLead));
    chk(spacingBad == 0, "R7 edge spacing", 32'(spacingBad), 32'd0);
    chk(strobeCnt == n, "R10 strobe count", 32'(strobeCnt), 32'(n));
    chk(strobeBad == 0, "R10 strobe on final edge", 32'(strobeBad), 32'd0);
    chk(assertCnt == 1 && deassertCnt == 1, "R11 R2 single frame",
        32'(assertCnt * 16 + deassertCnt), 32'h11);
    chk(trailCyc == dv / 2, "R11 trail", 32'(trailCyc), 32'(dv / 2));
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [4] = '{1, 3, 8, 32};
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(frameSel == 1'b1, "R1 frame inactive in reset", 32'(frameSel), 32'd1);
    chk(rxStrobe == 1'b0, "R1 strobe low in reset", 32'(rxStrobe), 32'd0);
    chk(rxData == '0, "R1 rxData zero", rxData, 32'd0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(sck == 1'b0, "R1 sck idle after reset", 32'(sck), 32'd0);
    chk(txReady == 1'b1, "R1 ready after reset", 32'(txReady), 32'd1);
    chk(frameSel == 1'b1, "R1 frame inactive after reset", 32'(frameSel), 32'd1);
    for (int m = 0; m < 16; m++)
      for (int o = 0; o < 2; o++)
        for (int l = 0; l < 4; l++)
          xfer(m[0], m[1], m[2], m[3], m[0] ^ o[0], o[0], lens[l], 4, 1);
    // R11 bursts and R7 wider ratios
    xfer(0, 0, 1, 0, 0, 0, 7, 6, 3);
    xfer(1, 1, 0, 1, 1, 1, 32, 6, 3);
    xfer(0, 1, 1, 1, 1, 0, 5, 10, 4);
    xfer(1, 0, 1, 0, 0, 1, 2, 254, 1);
    xfer(0, 0, 1, 0, 1, 1, 1, 4, 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule